// File: doc/BRIEF.md
# Interleaved Storage Display Sequencer

This block shares one trace memory of 2^ADDR_W words (1024 words of 8 bits by default) between two users. One user is the sweep, which stores amplitude samples. The other is the display refresh, which reads the stored trace back. A small phase counter splits every display cycle into a write half and a read half.

In the write half, the memory is addressed by the horizontal sample code, and the amplitude sample is stored there on a single active-low write strobe. In the read half, a free-running display counter supplies the address. A read strobe then copies the addressed word into the output latch that feeds the display converter. The converter sample-enable strobe is raised only in the read half, so both sample codes are stable across every write.

A clear request zeroes the whole memory and then restarts sequencing from the top of the display trace.

Top module: `trace_store_seq`

## Requirements
- R1: Each display cycle lasts 2*PH_LEN clocks, with PH_LEN = 4 by default. The phase offset runs from 0 to 2*PH_LEN-1. `rd_phase` is low for offsets below PH_LEN and high for the rest.
- R2: `mem_addr` equals `x_code` in the write half and the display counter in the read half.
- R3: `wr_n` is low for exactly one clock per cycle, at offset 1. At the end of that clock, `y_code` is stored at address `x_code`.
- R4: The display counter steps by one when the cycle passes from the write half to the read half (offset PH_LEN-1 to PH_LEN). It wraps from 2^ADDR_W-1 to 0. After reset or a clear, the first read-half address is 0, and successive cycles read addresses 0, 1, 2 and so on.
- R5: `ramp_restart` is a one-clock pulse at offset PH_LEN. It is raised only in a cycle whose read address is 0.
- R6: `rd_stb` is high for one clock at offset PH_LEN+1. At the end of that clock, `disp_word` takes the word at the read address. It holds that word until the next read strobe or clear.
- R7: `smp_en` is high for one clock per cycle, at offset PH_LEN+2, which lies in the read half.
- R8: A `clr_req` seen while no clear is running has three effects on the next edge. It zeroes `disp_word`, raises `clr_busy` for exactly 2^ADDR_W clocks, and writes 0 to every address. While busy, all strobes stay idle and sample codes are ignored. `clr_done` then pulses for one clock, in the first clock at offset 0 with the display counter at its top value.
- R9: A synchronous active-high `rst` returns the block to offset 0 with the display counter at its top value, `disp_word` at 0 and no clear running.
- R10: When a cycle writes the address that the same cycle reads, the latched word is the value just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_req | input | 1 | Request to zero the trace memory and restart |
| x_code | input | ADDR_W | Horizontal sample code, used as the write address |
| y_code | input | DATA_W | Amplitude sample, used as the write data |
| disp_word | output | DATA_W | Latched word for the display converter |
| ramp_restart | output | 1 | Pulse restarting the display sweep at address 0 |
| smp_en | output | 1 | Sample-enable strobe for both converters |
| rd_phase | output | 1 | High in the read half of the cycle |
| mem_addr | output | ADDR_W | Address currently applied to the memory |
| wr_n | output | 1 | Active-low write strobe |
| rd_stb | output | 1 | Read strobe loading the display latch |
| clr_busy | output | 1 | High while the memory is being zeroed |
| clr_done | output | 1 | One-clock pulse when zeroing has finished |

## Verification
A phase counter that slips shows at the strobe and phase outputs within one cycle of eight clocks. A display counter that steps at the wrong point shows as a wrong `mem_addr` in the next read half. A missed wrap or a skipped counter reset shows as a misplaced `ramp_restart` by the end of one full display pass. A corrupted or mis-addressed store stays hidden until its address is read back, which takes up to 2^ADDR_W cycles. For that reason the stimulus reads every address at least twice, and it rewrites a random mix of addresses before each read.

// File: rtl/trace_store_seq.sv
module trace_store_seq #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int PH_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_req,
  input  logic [ADDR_W-1:0] x_code,
  input  logic [DATA_W-1:0] y_code,
  output logic [DATA_W-1:0] disp_word,
  output logic              ramp_restart,
  output logic              smp_en,
  output logic              rd_phase,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wr_n,
  output logic              rd_stb,
  output logic              clr_busy,
  output logic              clr_done
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PH_W  = $clog2(2 * PH_LEN);
  localparam logic [PH_W-1:0] LAST   = PH_W'(2 * PH_LEN - 1);
  localparam logic [PH_W-1:0] WR_AT  = PH_W'(1);
  localparam logic [PH_W-1:0] PRE    = PH_W'(PH_LEN - 1);
  localparam logic [PH_W-1:0] TURN   = PH_W'(PH_LEN);
  localparam logic [PH_W-1:0] RD_AT  = PH_W'(PH_LEN + 1);
  localparam logic [PH_W-1:0] SMP_AT = PH_W'(PH_LEN + 2);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PH_W-1:0]   ph;
  logic [ADDR_W-1:0] disp_cnt, fill_addr;
  logic              filling, done_q;
  logic [DATA_W-1:0] latch_q;

  wire start_clr = clr_req && !filling;

  assign rd_phase     = ph >= TURN;
  assign mem_addr     = filling ? fill_addr : (rd_phase ? disp_cnt : x_code);
  assign wr_n         = !(ph == WR_AT && !filling);
  assign rd_stb       = ph == RD_AT && !filling;
  assign smp_en       = ph == SMP_AT && !filling;
  assign ramp_restart = ph == TURN && disp_cnt == '0 && !filling;
  assign disp_word    = latch_q;
  assign clr_busy     = filling;
  assign clr_done     = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= '0;
      disp_cnt  <= '1;
      filling   <= 1'b0;
      fill_addr <= '0;
      done_q    <= 1'b0;
      latch_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_clr) begin
        filling   <= 1'b1;
        fill_addr <= '0;
        ph        <= '0;
        disp_cnt  <= '1;
        latch_q   <= '0;
      end else if (filling) begin
        fill_addr <= fill_addr + 1'b1;
        if (fill_addr == '1) begin
          filling <= 1'b0;
          done_q  <= 1'b1;
        end
      end else begin
        ph <= (ph == LAST) ? '0 : ph + PH_W'(1);
        if (ph == PRE) disp_cnt <= disp_cnt + 1'b1;
        if (rd_stb) latch_q <= mem[disp_cnt];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (filling) mem[fill_addr] <= '0;
    else if (!wr_n) mem[x_code] <= y_code;
  end
endmodule

// File: rtl/trace_store_seq_chk.sv
module trace_store_seq_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_req,
  input logic [DATA_W-1:0] disp_word,
  input logic              ramp_restart,
  input logic              smp_en,
  input logic              rd_phase,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              wr_n,
  input logic              rd_stb,
  input logic              clr_busy,
  input logic              clr_done
);
  AST_WR_IN_WRITE: assert property (@(posedge clk) disable iff (rst) !wr_n |-> !rd_phase); // R3
  AST_RD_IN_READ: assert property (@(posedge clk) disable iff (rst) rd_stb |-> rd_phase); // R6
  AST_SMP_IN_READ: assert property (@(posedge clk) disable iff (rst) smp_en |-> rd_phase); // R7
  AST_RAMP_AT_ZERO: assert property (@(posedge clk) disable iff (rst) ramp_restart |-> (rd_phase && mem_addr == '0)); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst) (!rd_stb && !(clr_req && !clr_busy)) |=> $stable(disp_word)); // R6
  AST_BUSY_ZERO: assert property (@(posedge clk) disable iff (rst) clr_busy |-> disp_word == '0); // R8
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst) clr_busy |-> (wr_n && !rd_stb && !smp_en && !ramp_restart)); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst) clr_done |-> ($past(clr_busy) && !clr_busy && !rd_phase)); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) $countones({!wr_n, rd_stb, smp_en}) <= 1); // R1
endmodule

bind trace_store_seq trace_store_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .clr_req(clr_req), .disp_word(disp_word),
  .ramp_restart(ramp_restart), .smp_en(smp_en), .rd_phase(rd_phase),
  .mem_addr(mem_addr), .wr_n(wr_n), .rd_stb(rd_stb),
  .clr_busy(clr_busy), .clr_done(clr_done)
);

// File: tb/trace_store_seq_bench.sv
module trace_store_seq_bench;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int PL = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1, clr_req = 1'b0;
  logic [AW-1:0] x_code = '0;
  logic [DW-1:0] y_code = '0;
  logic [DW-1:0] disp_word;
  logic ramp_restart, smp_en, rd_phase, wr_n, rd_stb, clr_busy, clr_done;
  logic [AW-1:0] mem_addr;

  int total = 0, bad = 0;
  logic [DW-1:0] model [DEPTH];
  int rd_ptr = 0;
  logic [DW-1:0] prev_word = '0;

  always #10 clk = ~clk;

  trace_store_seq #(.ADDR_W(AW), .DATA_W(DW), .PH_LEN(PL)) u_trace_store_seq (
    .clk(clk), .rst(rst), .clr_req(clr_req), .x_code(x_code), .y_code(y_code),
    .disp_word(disp_word), .ramp_restart(ramp_restart), .smp_en(smp_en),
    .rd_phase(rd_phase), .mem_addr(mem_addr), .wr_n(wr_n), .rd_stb(rd_stb),
    .clr_busy(clr_busy), .clr_done(clr_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input int addr);
    return model[addr];
  endfunction

  function automatic logic [AW-1:0] rnd_x();
    return AW'($urandom);
  endfunction

  function automatic logic [DW-1:0] rnd_y();
    return DW'($urandom);
  endfunction

  task automatic one_cycle(input logic [AW-1:0] nx, input logic [DW-1:0] ny);
    logic [AW-1:0] cx;
    logic [DW-1:0] cy;
    cx = x_code;
    cy = y_code;
    for (int i = 0; i < 2 * PL; i++) begin
      if (i > 0) @(negedge clk);
      chk(rd_phase == (i >= PL), "R1 phase", int'(rd_phase), int'(i >= PL));
      if (i < PL) chk(mem_addr == cx, "R2 write address", int'(mem_addr), int'(cx));
      else chk(mem_addr == AW'(rd_ptr), "R4 read address", int'(mem_addr), rd_ptr);
      chk(wr_n == !(i == 1), "R3 write strobe", int'(wr_n), int'(!(i == 1)));
      chk(rd_stb == (i == PL + 1), "R6 read strobe", int'(rd_stb), int'(i == PL + 1));
      chk(smp_en == (i == PL + 2), "R7 sample enable", int'(smp_en), int'(i == PL + 2));
      chk(ramp_restart == (i == PL && rd_ptr == 0), "R5 ramp restart", int'(ramp_restart),
          int'(i == PL && rd_ptr == 0));
      if (i == 0) chk(disp_word == prev_word, "R6 hold", int'(disp_word), int'(prev_word));
      if (i == 1) model[cx] = cy;
      if (i == PL + 2) begin
        if (int'(cx) == rd_ptr)
          chk(disp_word == exp_read(rd_ptr), "R10 read after write", int'(disp_word), int'(exp_read(rd_ptr)));
        else
          chk(disp_word == exp_read(rd_ptr), "R6 read word", int'(disp_word), int'(exp_read(rd_ptr)));
        prev_word = disp_word;
        x_code = nx;
        y_code = ny;
      end
    end
    @(negedge clk);
    rd_ptr = (rd_ptr + 1) % DEPTH;
  endtask

  task automatic do_clear(input logic [AW-1:0] fx, input logic [DW-1:0] fy);
    int n;
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    n = 0;
    while (clr_busy && n < DEPTH + 8) begin
      chk(disp_word == '0, "R8 zero during clear", int'(disp_word), 0);
      if (n == 3) chk(wr_n && !rd_stb && !smp_en, "R8 strobes idle", int'({wr_n, rd_stb, smp_en}), 4);
      x_code = rnd_x();
      y_code = rnd_y();
      if (n == 5) clr_req = 1'b1;
      if (n == 6) clr_req = 1'b0;
      if (n == DEPTH - 1) begin
        x_code = fx;
        y_code = fy;
      end
      n++;
      @(negedge clk);
    end
    chk(n == DEPTH, "R8 busy length", n, DEPTH);
    chk(clr_done == 1'b1, "R8 done pulse", int'(clr_done), 1);
    chk(!rd_phase, "R8 restart in write half", int'(rd_phase), 0);
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    rd_ptr = 0;
    prev_word = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    x_code = '0;
    y_code = 8'h5A;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state at first clock after release
    chk(disp_word == '0, "R9 latch", int'(disp_word), 0);
    chk(!rd_phase && wr_n && !rd_stb && !smp_en, "R9 phase", int'(rd_phase), 0);
    chk(!clr_busy && !clr_done, "R9 clear idle", int'(clr_busy), 0);
    // R9/R4: counter top value wraps to 0 on first turn
    one_cycle(10'd3, 8'h11);
    one_cycle(10'd1, 8'hC3);
    repeat (3) @(negedge clk);
    do_clear('0, rnd_y());
    for (int k = 0; k < DEPTH; k++) begin
      logic [AW-1:0] nx;
      nx = (k == DEPTH - 1) ? rnd_x() : AW'(k + 1);
      one_cycle(nx, rnd_y());
    end
    for (int k = 0; k < DEPTH; k++) begin
      logic [AW-1:0] nx;
      logic [DW-1:0] ny;
      nx = rnd_x();
      ny = ($urandom % 4 == 0) ? rnd_y() : model[nx];
      if (k == 10) nx = '1;
      if (k == 11) nx = '0;
      one_cycle(nx, ny);
    end
    one_cycle(AW'(DEPTH - 1), 8'hFF);
    one_cycle(10'd2, 8'h01);
    repeat (5) @(negedge clk);
    do_clear(10'd1, 8'h77);
    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] nx;
      nx = (k % 3 == 0) ? AW'(k + 1) : rnd_x();
      one_cycle(nx, rnd_y());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule